// File: doc/BRIEF.md
# Iterative AES-128 Cipher Round Engine

This block encrypts a single 128-bit block with AES-128. A short controller sequences the work. On an accepted start it first XORs the plaintext with round key 0. It then runs nine full rounds and one closing round, at one round per clock cycle. Each full round applies byte substitution, row rotation, column mixing and the key XOR. The closing round skips the column mixing.

The round keys come from outside the block. The engine drives `round_idx` to name the key it needs in the current cycle, and the key source must answer combinationally on `round_key`.

`data_out` always shows the working state register. Once `done` pulses, that register holds the ciphertext. It keeps that value until the next accepted start.

Top module: `aes_round_engine`

## Requirements
- R1: After reset `busy` and `done` are 0, `round_idx` is 0 and `data_out` is all zeros.
- R2: A `start` seen at a clock edge while the engine is idle (neither `busy` nor `done`) loads `data_in XOR round_key` into the state. At the same edge `round_key` must be key 0, because `round_idx` is 0 when idle. From the next cycle `busy` is 1 and `round_idx` is 1.
- R3: While busy, `round_idx` rises by one each cycle from 1 to 10 and names the round key used at the next edge. It reads 0 when idle and during the `done` cycle.
- R4: Each of rounds 1 to 9 transforms the state in four steps. The state is bytes b0..b15, where b0 sits in bits 127:120 and byte 4c+r is row r of column c.
  - Every byte passes through the AES S-box.
  - Row r rotates left by r byte positions.
  - Each column is multiplied in GF(2^8) by the circulant matrix with first row {02 03 01 01}, using the reduction constant 0x1B.
  - The result is XORed with `round_key`.
- R5: Round 10 applies the S-box, the row rotation and the key XOR, but no column mixing.
- R6: `done` is 1 for exactly one cycle. That cycle comes 11 clock edges after the edge that accepted `start`, and in it `data_out` equals the ciphertext.
- R7: Outside busy cycles, `data_out` keeps its value until an accepted start.
- R8: `start` has no effect while `busy` or `done` is 1. The running encryption is unchanged and no new one begins.
- R9: Plaintext 00112233445566778899aabbccddeeff with key 000102030405060708090a0b0c0d0e0f gives ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to encrypt `data_in`; honoured only when idle |
| data_in | input | 128 | Plaintext block, b0 in bits 127:120 |
| round_key | input | 128 | Round key selected by `round_idx` |
| round_idx | output | 4 | Index of the round key needed this cycle (0..10) |
| busy | output | 1 | Rounds 1 to 10 in progress |
| done | output | 1 | One-cycle pulse when the ciphertext is in `data_out` |
| data_out | output | 128 | Working state; ciphertext from the `done` cycle onward |

## Verification
Every result of this engine has a fixed time slot:
- The whitened state is visible one edge after the accepting edge.
- The state after round r is visible r+1 edges after that edge.
- `done` and the ciphertext appear at edge 11.
- The held value is visible from edge 12 onward.

The bench drives its inputs on falling edges and samples at the following falling edge, one edge per step. Every intermediate state is compared with a model built separately in the bench, including its own S-box, column mixing and key expansion. Starts injected during busy and done cycles are followed by checks at the exact edges where a wrongly accepted start would show.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;
  localparam int NUM_ROUNDS = 10;
  localparam int BLK_BYTES  = 16;
  localparam int NUM_COLS   = 4;
  localparam int IDX_W      = $clog2(NUM_ROUNDS + 2);

  typedef enum logic [1:0] {PH_IDLE, PH_MID, PH_FINAL, PH_DONE} phase_t;

  // Byte i of a 128-bit block, b0 in the top bits.
  function automatic logic [7:0] blk_byte(input logic [127:0] blk, input int i);
    return blk[127-8*i -: 8];
  endfunction

  // Doubling in GF(2^8): shift, then reduce when bit 7 fell out.
  function automatic logic [7:0] gf_x2(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_x3(input logic [7:0] b);
    return gf_x2(b) ^ b;
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] m;
    acc = 8'h00;
    m   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ m;
      m = gf_x2(m);
    end
    return acc;
  endfunction

  // Inverse as x^254 by square-and-multiply; 0 maps to 0.
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] res;
    logic [7:0] ex;
    res = 8'h01;
    ex  = 8'd254;
    for (int i = 7; i >= 0; i--) begin
      res = gf_mul(res, res);
      if (ex[i]) res = gf_mul(res, x);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
    logic [15:0] t;
    t = {b, b};
    return t[15-k -: 8];
  endfunction

  function automatic logic [7:0] sbox_fn(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // Row r of the output takes its bytes from column (c + r) mod 4.
  function automatic logic [127:0] rot_rows(input logic [127:0] s);
    logic [127:0] o;
    o = '0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = blk_byte(s, 4*(((c + r) % 4)) + r);
    return o;
  endfunction

  // One column, row 0 in bits 31:24.
  function automatic logic [31:0] mix_col(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    a0 = col[31:24];
    a1 = col[23:16];
    a2 = col[15:8];
    a3 = col[7:0];
    return {gf_x2(a0) ^ gf_x3(a1) ^ a2 ^ a3,
            a0 ^ gf_x2(a1) ^ gf_x3(a2) ^ a3,
            a0 ^ a1 ^ gf_x2(a2) ^ gf_x3(a3),
            gf_x3(a0) ^ a1 ^ a2 ^ gf_x2(a3)};
  endfunction
endpackage

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes
  import aes_eng_pkg::*;
(
  input  logic [127:0] state_in,
  output logic [127:0] state_out
);
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    logic [7:0] lane_in;
    logic [7:0] lane_out;
    assign lane_in = state_in[127-8*g -: 8];
    always_comb lane_out = sbox_fn(lane_in);
    assign state_out[127-8*g -: 8] = lane_out;
  end
endmodule

// File: rtl/aes_mix_columns.sv
module aes_mix_columns
  import aes_eng_pkg::*;
(
  input  logic [127:0] state_in,
  output logic [127:0] state_out
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [31:0] col_in;
    logic [31:0] col_out;
    assign col_in = state_in[127-32*c -: 32];
    always_comb col_out = mix_col(col_in);
    assign state_out[127-32*c -: 32] = col_out;
  end
endmodule

// File: rtl/aes_round_dp.sv
module aes_round_dp
  import aes_eng_pkg::*;
(
  input  logic [127:0] state_q,
  input  logic [127:0] round_key,
  input  logic         last_round,
  output logic [127:0] round_out
);
  logic [127:0] subbed;
  logic [127:0] shifted;
  logic [127:0] mixed;
  logic [127:0] pre_key;

  aes_sub_bytes u_sub (
    .state_in  (state_q),
    .state_out (subbed)
  );

  always_comb shifted = rot_rows(subbed);

  aes_mix_columns u_mix (
    .state_in  (shifted),
    .state_out (mixed)
  );

  assign pre_key   = last_round ? shifted : mixed;
  assign round_out = pre_key ^ round_key;
endmodule

// File: rtl/aes_round_ctrl.sv
module aes_round_ctrl
  import aes_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             load_init,
  output logic             load_round,
  output logic             last_round,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] round_idx
);
  phase_t           phase_q;
  logic [IDX_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      count_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          count_q <= IDX_W'(1);
          phase_q <= (NUM_ROUNDS > 1) ? PH_MID : PH_FINAL;
        end
        PH_MID: begin
          count_q <= count_q + 1'b1;
          if (count_q == IDX_W'(NUM_ROUNDS - 1)) phase_q <= PH_FINAL;
        end
        PH_FINAL: begin
          count_q <= count_q + 1'b1;
          phase_q <= PH_DONE;
        end
        default: begin
          count_q <= '0;
          phase_q <= PH_IDLE;
        end
      endcase
    end
  end

  assign load_init  = (phase_q == PH_IDLE) && start;
  assign load_round = (phase_q == PH_MID) || (phase_q == PH_FINAL);
  assign last_round = (phase_q == PH_FINAL);
  assign busy       = load_round;
  assign done       = (phase_q == PH_DONE);
  assign round_idx  = done ? '0 : count_q;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> (busy && round_idx == IDX_W'(1)));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_round) |=> (busy && round_idx == IDX_W'($past(round_idx) + 1'b1)));

  // R6
  done_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> (done && !busy));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy && round_idx == '0));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!busy && !done));
endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine
  import aes_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [127:0]     data_in,
  input  logic [127:0]     round_key,
  output logic [IDX_W-1:0] round_idx,
  output logic             busy,
  output logic             done,
  output logic [127:0]     data_out
);
  logic         load_init;
  logic         load_round;
  logic         last_round;
  logic [127:0] round_out;
  logic [127:0] state_q;

  aes_round_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .load_init  (load_init),
    .load_round (load_round),
    .last_round (last_round),
    .busy       (busy),
    .done       (done),
    .round_idx  (round_idx)
  );

  aes_round_dp u_dp (
    .state_q    (state_q),
    .round_key  (round_key),
    .last_round (last_round),
    .round_out  (round_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state_q <= '0;
    else if (load_init)  state_q <= data_in ^ round_key;
    else if (load_round) state_q <= round_out;
  end

  assign data_out = state_q;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(start && !done)) |=> $stable(data_out));

  // R2
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> (data_out == $past(data_in ^ round_key)));
endmodule

// File: tb/tb_aes_round_engine.sv
module tb_aes_round_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] data_in = '0;
  logic [127:0] round_key;
  logic [3:0]   round_idx;
  logic         busy;
  logic         done;
  logic [127:0] data_out;

  logic [127:0] rk [0:10];
  logic [7:0]   sb [0:255];
  logic [127:0] expst [0:10];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign round_key = (round_idx <= 4'd10) ? rk[round_idx] : '0;

  aes_round_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .round_key(round_key), .round_idx(round_idx), .busy(busy),
    .done(done), .data_out(data_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Model arithmetic, written independently of the design.
  function automatic logic [7:0] m2(input logic [7:0] a);
    logic [8:0] t;
    t = {a, 1'b0};
    if (t[8]) t = t ^ 9'h11B;
    return t[7:0];
  endfunction

  function automatic logic [7:0] mmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = 0; x = a; y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = m2(x);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, o;
      inv = 0;
      for (int y = 1; y < 256; y++)
        if (x != 0 && mmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i);
      sb[x] = o;
    end
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [7:0]  rc;
    logic [31:0] t;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m2(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= 10; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] model_round(input logic [127:0] st, input logic [127:0] k,
                                               input bit final_rnd);
    logic [7:0] s [0:15];
    logic [7:0] t [0:15];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = sb[st[127-8*i -: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) t[4*c+r] = s[4*((c+r)%4)+r];
    if (!final_rnd)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[4*c+r] = mmul(t[4*c+r], 2) ^ mmul(t[4*c+(r+1)%4], 3) ^
                     t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
    else
      for (int i = 0; i < 16; i++) s[i] = t[i];
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o ^ k;
  endfunction

  task automatic run_vec(input logic [127:0] pt, input logic [127:0] key, input bit inject);
    expand(key);
    expst[0] = pt ^ rk[0];
    for (int r = 1; r <= 10; r++) expst[r] = model_round(expst[r-1], rk[r], r == 10);
    @(negedge clk);
    data_in = pt; start = 1'b1;
    @(negedge clk);
    start = 1'b0; data_in = ~pt;
    for (int r = 0; r < 10; r++) begin
      chk(data_out == expst[r], (r == 0) ? "R2" : "R4", $sformatf("state after step %0d", r),
          data_out, expst[r]);
      chk(round_idx == 4'(r + 1) && busy && !done, "R3", "index while busy",
          {124'h0, round_idx}, 128'(r + 1));
      if (inject && r == 4) start = 1'b1;  // R8: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1 && !busy, "R6", "done after 11 edges", {127'h0, done}, 128'h1);
    chk(data_out == expst[10], "R5", "ciphertext without final mixing", data_out, expst[10]);
    chk(round_idx == 4'd0, "R3", "index in done cycle", {124'h0, round_idx}, 128'h0);
    if (inject) start = 1'b1;  // R8: start during done cycle
    @(negedge clk);
    start = 1'b0;
    chk(!done && !busy, "R8", "no restart after ignored start", {126'h0, busy, done}, 128'h0);
    chk(data_out == expst[10], "R7", "ciphertext held", data_out, expst[10]);
    repeat (3) @(negedge clk);
    chk(data_out == expst[10] && !done, "R7", "ciphertext held later", data_out, expst[10]);
  endtask

  initial begin
    build_sbox();
    expand('0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && round_idx == 0 && data_out == '0, "R1", "reset state",
        data_out, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && round_idx == 0, "R1", "idle after reset",
        {124'h0, round_idx}, 128'h0);
    run_vec(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 1'b0);
    chk(data_out == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R9", "known answer",
        data_out, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_vec('0, '0, 1'b1);
    run_vec('1, '1, 1'b0);
    for (int v = 0; v < 4; v++)
      run_vec({$urandom, $urandom, $urandom, $urandom},
              {$urandom, $urandom, $urandom, $urandom}, v[0]);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule